// File: doc/BRIEF.md
# System Control Register Block

This block is the register file of a small controller. A word-addressed slave bus reaches sixteen 32-bit words. They hold general-purpose pin state, two groups of timer registers, a configuration command word, a capabilities word and an identifier. The block decodes each access and returns read data one cycle later. It refuses writes to the read-only words, and it reports bad accesses through a sticky error flag.

Two kinds of write have side effects. Any full-word write to the identifier word issues a one-cycle system reset request, and the identifier keeps its value. A full-word write to the configuration command word whose low half-word is 0x000E issues a one-cycle shutdown request.

The timers count in a separate block. That block reads the control and compare values from this one, receives write strobes for the control and counter words, supplies its live count values, and requests a one-shot stop. The input pins reach the register through a two-flop synchroniser. Until the first samples have passed through it, the strapping parameter is read instead.

Top module: `sysctl_regs`

## Requirements
- R1: The word index is byte address bits [5:2]. Reset gives zero for GPIO output, interrupt enable, both timer controls and both compares. After reset, index 13 reads 1 (ready), index 14 reads parameter CAPS, index 15 reads parameter SYS_ID, the error flag is 0 and all pulse outputs are 0.
- R2: The word read by a valid read appears on rdata after the next clock edge. rdata holds its value while no read is presented.
- R3: Index 1 (GPIO output), index 2 (interrupt enable), index 5 (timer 0 compare) and index 9 (timer 1 compare) are read/write. Each drives its output port.
- R4: Index 0 reads the input pins, zero-extended, through two flops. A read presented in the first cycle after reset returns the STRAP parameter. A pin change is not seen by a read issued at the next edge, and is seen by a read one cycle after that.
- R5: Writes to index 0 and index 14 change nothing and set the error flag.
- R6: Indices 3, 7, 11 and 12 are reserved. Reads of them return 0, writes to them change nothing, and either access sets the error flag.
- R7: An access with byte enables other than 4'hF changes nothing, produces no pulse, returns 0 on rdata if it is a read, and sets the error flag.
- R8: The error flag stays set until err_ack is high in a cycle with no new error. An error in the same cycle as err_ack leaves it set.
- R9: A valid write to index 15 gives a one-cycle sys_rst_req pulse after the edge. The identifier reads unchanged afterwards.
- R10: A valid write to index 13 with wdata[15:0] == 16'h000E gives a one-cycle shutdown_req pulse. Other values give no pulse. Index 13 keeps reading 1.
- R11: Index 4 (timer 0) and index 8 (timer 1) store wdata[1:0]: bit 0 enable, bit 1 auto-restart. A write pulses tmr_ctrl_wr for that timer. tmr_stop clears the enable bit unless a control write to the same timer occurs in the same cycle, and then the write wins.
- R12: Index 6 (timer 0) and index 10 (timer 1) read the live tmr_cnt input. A write pulses tmr_cnt_wr for that timer, and tmr_cnt_wval carries the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte address |
| be | input | 4 | Byte enables; only 4'hF is valid |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Sticky access error flag |
| err_ack | input | 1 | Clears the error flag |
| gpio_pins | input | GPIO_W | Asynchronous input pins |
| gpio_out | output | 32 | GPIO output register |
| gpio_ie | output | 32 | GPIO interrupt enable register |
| tmr_ctrl | output | 2x2 | Timer control bits {auto-restart, enable} per timer |
| tmr_ctrl_wr | output | 2 | Control write strobe per timer |
| tmr_cmp | output | 2x32 | Timer compare values |
| tmr_cnt | input | 2x32 | Live timer counts |
| tmr_cnt_wr | output | 2 | Counter write strobe per timer |
| tmr_cnt_wval | output | 32 | Value of the last counter write |
| tmr_stop | input | 2 | One-shot stop request per timer |
| sys_rst_req | output | 1 | System reset request pulse |
| shutdown_req | output | 1 | Shutdown request pulse |

## Verification
The bench builds the block with GPIO_W = 8, STRAP = 8'hA5, SYS_ID = 32'hC0DE0042 and CAPS = 32'h00000F0F. The narrow pin width makes the zero-extension of index 0 visible. The non-default identifier and capabilities prove that the reset values come from the parameters rather than constants. A strap value different from the driven pins makes the one-cycle strap window and the two-flop latency observable at the read port.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int GPIO_W = 32,
  parameter logic [GPIO_W-1:0] STRAP = GPIO_W'(1),
  parameter logic [31:0] SYS_ID = 32'h10014D31,
  parameter logic [31:0] CAPS = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [5:0]       addr,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             err,
  input  logic             err_ack,
  input  logic [GPIO_W-1:0] gpio_pins,
  output logic [31:0]      gpio_out,
  output logic [31:0]      gpio_ie,
  output logic [1:0][1:0]  tmr_ctrl,
  output logic [1:0]       tmr_ctrl_wr,
  output logic [1:0][31:0] tmr_cmp,
  input  logic [1:0][31:0] tmr_cnt,
  output logic [1:0]       tmr_cnt_wr,
  output logic [31:0]      tmr_cnt_wval,
  input  logic [1:0]       tmr_stop,
  output logic             sys_rst_req,
  output logic             shutdown_req
);
  localparam logic [3:0] IX_PIN = 4'd0, IX_OUT = 4'd1, IX_IE = 4'd2;
  localparam logic [3:0] IX_CFG = 4'd13, IX_CAP = 4'd14, IX_ID = 4'd15;
  localparam logic [15:0] OFF_CMD = 16'h000E;

  logic [GPIO_W-1:0] sync1, sync2;
  logic [31:0] rmux;
  wire [3:0] idx  = addr[5:2];
  wire       full = &be;
  wire       wr   = req & we & full;
  wire       rsv  = (idx == 4'd3) | (idx == 4'd7) | (idx == 4'd11) | (idx == 4'd12);
  wire       ro   = (idx == IX_PIN) | (idx == IX_CAP);
  wire       bad  = req & (~full | rsv | (we & ro));

  always_comb begin
    rmux = '0;
    case (idx)
      IX_PIN: rmux[GPIO_W-1:0] = sync2;
      IX_OUT: rmux = gpio_out;
      IX_IE:  rmux = gpio_ie;
      4'd4:   rmux[1:0] = tmr_ctrl[0];
      4'd5:   rmux = tmr_cmp[0];
      4'd6:   rmux = tmr_cnt[0];
      4'd8:   rmux[1:0] = tmr_ctrl[1];
      4'd9:   rmux = tmr_cmp[1];
      4'd10:  rmux = tmr_cnt[1];
      IX_CFG: rmux[0] = 1'b1;
      IX_CAP: rmux = CAPS;
      IX_ID:  rmux = SYS_ID;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= STRAP;
      sync2 <= STRAP;
      rdata <= '0;
      err <= 1'b0;
      gpio_out <= '0;
      gpio_ie <= '0;
      tmr_ctrl <= '0;
      tmr_cmp <= '0;
      tmr_ctrl_wr <= '0;
      tmr_cnt_wr <= '0;
      tmr_cnt_wval <= '0;
      sys_rst_req <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      sync1 <= gpio_pins;
      sync2 <= sync1;
      if (req && !we) rdata <= full ? rmux : '0;
      err <= bad | (err & ~err_ack);
      if (wr && idx == IX_OUT) gpio_out <= wdata;
      if (wr && idx == IX_IE) gpio_ie <= wdata;
      for (int i = 0; i < 2; i++) begin
        if (wr && idx == 4'(4 + 4 * i)) tmr_ctrl[i] <= wdata[1:0];
        else if (tmr_stop[i]) tmr_ctrl[i][0] <= 1'b0;
        if (wr && idx == 4'(5 + 4 * i)) tmr_cmp[i] <= wdata;
        tmr_ctrl_wr[i] <= wr && idx == 4'(4 + 4 * i);
        tmr_cnt_wr[i] <= wr && idx == 4'(6 + 4 * i);
        if (wr && idx == 4'(6 + 4 * i)) tmr_cnt_wval <= wdata;
      end
      sys_rst_req <= wr && idx == IX_ID;
      shutdown_req <= wr && idx == IX_CFG && wdata[15:0] == OFF_CMD;
    end
  end

  // R9
  rst_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(req && we && (&be) && addr[5:2] == IX_ID));

  // R10
  shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(req && we && (&be) && addr[5:2] == IX_CFG && wdata[15:0] == OFF_CMD));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err) && !$past(err_ack)) |-> err);

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req && !we) |-> $stable(rdata));

  // R11
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_stop[0]) && !$past(req && we && (&be) && addr[5:2] == 4'd4)) |-> !tmr_ctrl[0][0]);
endmodule

// File: tb/tb_sysctl_regs.sv
module tb_sysctl_regs;
  localparam int GW = 8;
  localparam logic [GW-1:0] STRAP = 8'hA5;
  localparam logic [31:0] ID = 32'hC0DE0042, CAPS = 32'h00000F0F;

  logic clk = 0, rst_n = 0, req = 0, we = 0, err_ack = 0;
  logic [5:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0, rdata, gpio_out, gpio_ie, tmr_cnt_wval;
  logic [GW-1:0] gpio_pins = 8'h3C;
  logic [1:0][1:0] tmr_ctrl;
  logic [1:0][31:0] tmr_cmp;
  logic [1:0][31:0] tmr_cnt = {32'h1111_2222, 32'h3333_4444};
  logic [1:0] tmr_ctrl_wr, tmr_cnt_wr, tmr_stop = '0;
  logic err, sys_rst_req, shutdown_req;

  sysctl_regs #(.GPIO_W(GW), .STRAP(STRAP), .SYS_ID(ID), .CAPS(CAPS)) dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_out = 0, m_ie = 0, m_last = 0, m_wval = 0;
  logic [31:0] m_cmp [2] = '{0, 0};
  logic [1:0] m_ctrl [2] = '{0, 0};
  logic m_err = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] readf(int ix, logic [GW-1:0] pin);
    case (ix)
      0: return {24'h0, pin};
      1: return m_out;
      2: return m_ie;
      4: return {30'h0, m_ctrl[0]};
      5: return m_cmp[0];
      6: return tmr_cnt[0];
      8: return {30'h0, m_ctrl[1]};
      9: return m_cmp[1];
      10: return tmr_cnt[1];
      13: return 32'h1;
      14: return CAPS;
      15: return ID;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagof(int ix, bit full);
    if (!full) return "R7";
    case (ix)
      0: return "R4";
      1, 2, 5, 9: return "R3";
      3, 7, 11, 12: return "R6";
      4, 8: return "R11";
      6, 10: return "R12";
      13: return "R10";
      14: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic op(bit rq, bit w, int ix, logic [3:0] b, logic [31:0] d,
                    bit ack, logic [1:0] stp, logic [GW-1:0] pin_exp);
    bit full = &b;
    bit wr = rq && w && full;
    bit rsv = (ix == 3) || (ix == 7) || (ix == 11) || (ix == 12);
    bit bad = rq && (!full || rsv || (w && (ix == 0 || ix == 14)));
    string t = tagof(ix, full);
    logic [31:0] exp_rd = (rq && !w) ? (full ? readf(ix, pin_exp) : 32'h0) : m_last;
    @(negedge clk);
    req = rq; we = w; addr = 6'(ix << 2); be = b; wdata = d; err_ack = ack; tmr_stop = stp;
    @(negedge clk);
    req = 0; we = 0; err_ack = 0; tmr_stop = 0;
    m_err = bad | (m_err & !ack);
    if (wr) begin
      if (ix == 1) m_out = d;
      if (ix == 2) m_ie = d;
      if (ix == 5) m_cmp[0] = d;
      if (ix == 9) m_cmp[1] = d;
      if (ix == 6 || ix == 10) m_wval = d;
    end
    for (int i = 0; i < 2; i++) begin
      if (wr && ix == 4 + 4 * i) m_ctrl[i] = d[1:0];
      else if (stp[i]) m_ctrl[i][0] = 1'b0;
    end
    m_last = exp_rd;
    check({t, " rdata"}, rdata, exp_rd);
    check({t, " R8 err"}, {31'h0, err}, {31'h0, m_err});
    check("R9 sys_rst_req", {31'h0, sys_rst_req}, {31'h0, wr && ix == 15});
    check("R10 shutdown_req", {31'h0, shutdown_req}, {31'h0, wr && ix == 13 && d[15:0] == 16'h000E});
    check("R3 gpio_out", gpio_out, m_out);
    check("R3 gpio_ie", gpio_ie, m_ie);
    check("R3 tmr_cmp0", tmr_cmp[0], m_cmp[0]);
    check("R3 tmr_cmp1", tmr_cmp[1], m_cmp[1]);
    check("R11 tmr_ctrl", {28'h0, tmr_ctrl}, {28'h0, m_ctrl[1], m_ctrl[0]});
    check("R11 tmr_ctrl_wr", {30'h0, tmr_ctrl_wr}, {30'h0, wr && ix == 8, wr && ix == 4});
    check("R12 tmr_cnt_wr", {30'h0, tmr_cnt_wr}, {30'h0, wr && ix == 10, wr && ix == 6});
    check("R12 tmr_cnt_wval", tmr_cnt_wval, m_wval);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 err reset", {31'h0, err}, 32'h0);
    check("R1 rdata reset", rdata, 32'h0);
    check("R1 pulses reset", {28'h0, sys_rst_req, shutdown_req, |tmr_ctrl_wr, |tmr_cnt_wr}, 32'h0);
    rst_n = 1;
    // R4: first read after reset returns strap, later reads return pins
    op(1, 0, 0, 4'hF, 0, 0, 0, STRAP);
    op(1, 0, 0, 4'hF, 0, 0, 0, 8'h3C);
    // R1 reset reads
    for (int ix = 1; ix < 16; ix++) op(1, 0, ix, 4'hF, 0, 0, 0, 8'h3C);
    m_err = 0;
    op(1, 0, 13, 4'hF, 0, 1, 0, 8'h3C);
    // R4 pin change latency
    @(negedge clk) gpio_pins = 8'h5A;
    op(1, 0, 0, 4'hF, 0, 0, 0, 8'h3C);
    op(1, 0, 0, 4'hF, 0, 0, 0, 8'h5A);
    // R5 read-only writes
    op(1, 1, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 8'h5A);
    op(1, 1, 14, 4'hF, 32'h1234_5678, 0, 0, 8'h5A);
    op(1, 0, 14, 4'hF, 0, 0, 0, 8'h5A);
    // R8 ack alone clears, ack with new error keeps set
    op(0, 0, 0, 4'hF, 0, 1, 0, 8'h5A);
    op(1, 0, 7, 4'hF, 0, 0, 0, 8'h5A);
    op(1, 0, 12, 4'hF, 0, 1, 0, 8'h5A);
    op(0, 0, 0, 4'hF, 0, 1, 0, 8'h5A);
    // R7 partial byte enables
    op(1, 1, 1, 4'h3, 32'hDEAD_BEEF, 0, 0, 8'h5A);
    op(1, 1, 15, 4'h7, 0, 0, 0, 8'h5A);
    op(1, 0, 15, 4'hE, 0, 0, 0, 8'h5A);
    // R9 identifier write
    op(1, 1, 15, 4'hF, 32'h0, 1, 0, 8'h5A);
    op(1, 0, 15, 4'hF, 0, 0, 0, 8'h5A);
    // R10 shutdown command and near-miss
    op(1, 1, 13, 4'hF, 32'hABCD_000E, 0, 0, 8'h5A);
    op(1, 1, 13, 4'hF, 32'h0000_000F, 0, 0, 8'h5A);
    op(1, 0, 13, 4'hF, 0, 0, 0, 8'h5A);
    // R11 stop alone, stop with same-cycle write
    op(1, 1, 4, 4'hF, 32'h3, 0, 0, 8'h5A);
    op(0, 0, 0, 4'hF, 0, 0, 2'b01, 8'h5A);
    op(1, 1, 8, 4'hF, 32'h1, 0, 2'b10, 8'h5A);
    op(1, 0, 8, 4'hF, 0, 0, 0, 8'h5A);
    // R12 counters
    op(1, 0, 6, 4'hF, 0, 0, 0, 8'h5A);
    op(1, 1, 10, 4'hF, 32'hCAFE_F00D, 0, 0, 8'h5A);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int ix = int'($urandom % 16);
      logic [3:0] b = ($urandom % 6 == 0) ? 4'($urandom) : 4'hF;
      logic [31:0] d = $urandom;
      if (ix == 13 && ($urandom % 3 == 0)) d[15:0] = 16'h000E;
      op(($urandom % 8) != 0, $urandom % 2 == 1, ix, b, d, ($urandom % 8) == 0,
         2'($urandom % 4 == 0 ? $urandom : 0), 8'h5A);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule